// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked user and an external asynchronous static RAM of 262,144 words of 4 bits. The user hands over one request at a time (read or write, an 18-bit word address and, for writes, a 4-bit value) through a valid/ready handshake. The sequencer then drives the memory address, the active-low select, write and output-enable strobes and the data pins. It returns read data, or reports that a write has finished, with a one-cycle response pulse.

Every memory timing interval is a parameter in whole clock cycles: the read access time, the write pulse width, the data setup before the end of the pulse and the bus turnaround after a read. The write pulse length is the larger of the pulse width and the data setup figures. Output enable stays high through every write, so the memory never drives the pins while the sequencer does, and the short write pulse figure is enough. The address changes only while select and write enable are both high. The data pins are split into an output value, an output enable and an input value, so that the pad ring can build the tri-state buffer.

Top module: `asram_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. A `req_valid` raised while `req_ready` is 0 and dropped before `req_ready` returns has no effect on the memory.
- R3: A read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles. It captures `mem_dq_i` on the edge that ends that window, and presents the value on `rsp_rdata` with `rsp_valid`=1, RD_CYC+TA_CYC cycles after the accepting edge.
- R4: During a write, `mem_oe_n` stays 1 while `mem_we_n` is 0, and `mem_we_n` is 0 only while `mem_cs_n` is 0.
- R5: `mem_dq_oe` is 1 only while `mem_oe_n` is 1 and `mem_cs_n` is 0. It is 1 for the whole write pulse and for one more cycle after `mem_we_n` rises, then 0.
- R6: `mem_addr` does not change between two consecutive cycles in which `mem_cs_n` is 0.
- R7: `req_ready` is 0 from the accepting edge until the response. `rsp_valid` is a single-cycle pulse. For a write it comes PULSE+1 cycles after the accepting edge, where PULSE = max(WP_CYC, DS_CYC).
- R8: A read returns the value most recently written to the same address, including a read accepted in the cycle right after a write's response.
- R9: The write pulse (`mem_we_n`=0) lasts exactly max(WP_CYC, DS_CYC) cycles, with `mem_dq_o` holding the write value throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write value |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read value |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W | Value for the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | DATA_W | Value seen on the data pins |

## Verification
A read response is due RD_CYC+TA_CYC cycles after its accepting edge, and a write response PULSE+1 cycles after it. The driver stamps each accepted request with its due cycle, and the monitor compares the stamp with the cycle count on the falling edge where `rsp_valid` is seen. The memory model returns the inverse of the true data until the read window has been open for RD_CYC cycles, so a capture one edge early returns wrong data. The model also counts the falling edges of each write pulse and checks the strobe and drive-enable states on every falling edge.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_TURN   = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WREC   = 3'd4
    } seq_state_e;

    // Memory-side strobes and the drive enable, registered as one word.
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic strobe_t strobes_for(seq_state_e s);
        strobe_t r;
        r = STROBE_QUIET;
        case (s)
            ST_READ: begin
                r.cs_n = 1'b0;
                r.oe_n = 1'b0;
            end
            ST_WPULSE: begin
                r.cs_n  = 1'b0;
                r.we_n  = 1'b0;
                r.drive = 1'b1;
            end
            ST_WREC: begin
                r.cs_n  = 1'b0;
                r.drive = 1'b1;
            end
            default: r = STROBE_QUIET;
        endcase
        return r;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/asram_interval_timer.sv
module asram_interval_timer #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_seq_fsm.sv
module asram_seq_fsm
    import asram_pkg::*;
#(
    parameter int unsigned RD_CYC    = 3,
    parameter int unsigned PULSE_CYC = 2,
    parameter int unsigned TA_CYC    = 1,
    parameter int unsigned CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             done_q,
    output strobe_t          strobe_q
);
    seq_state_e state_q, state_d;
    logic       finish;

    assign ready  = (state_q == ST_IDLE);
    assign accept = ready && req_valid;

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        finish   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    load = 1'b1;
                    if (req_write) begin
                        state_d  = ST_WPULSE;
                        load_val = CNT_W'(PULSE_CYC - 1);
                    end else begin
                        state_d  = ST_READ;
                        load_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (expired) begin
                    capture  = 1'b1;
                    load     = 1'b1;
                    load_val = CNT_W'(TA_CYC - 1);
                    state_d  = ST_TURN;
                end
            end
            ST_TURN: begin
                if (expired) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WPULSE: begin
                if (expired) begin
                    state_d = ST_WREC;
                end
            end
            ST_WREC: begin
                finish  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            strobe_q <= STROBE_QUIET;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            strobe_q <= strobes_for(state_d);
            done_q   <= finish;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) accept |=> !ready); // R7
    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst) !strobe_q.we_n |-> !strobe_q.cs_n); // R4
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst) !strobe_q.we_n |-> strobe_q.oe_n); // R4
    AST_DRIVE_SAFE: assert property (@(posedge clk) disable iff (rst) strobe_q.drive |-> (strobe_q.oe_n && !strobe_q.cs_n)); // R5
    AST_DRIVE_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst) $rose(strobe_q.we_n) |-> strobe_q.drive); // R5
endmodule

// File: rtl/asram_seq_datapath.sv
module asram_seq_datapath #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= mem_dq_i;
            end
        end
    end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 4,
    parameter int unsigned RD_CYC = 3,
    parameter int unsigned WP_CYC = 2,
    parameter int unsigned DS_CYC = 2,
    parameter int unsigned TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned PULSE_CYC = max_u(WP_CYC, DS_CYC);
    localparam int unsigned CNT_W     = cnt_width(max_u(max_u(RD_CYC, PULSE_CYC), TA_CYC));

    logic             load, expired, accept, capture;
    logic [CNT_W-1:0] load_val;
    strobe_t          strobe_q;

    asram_interval_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    asram_seq_fsm #(
        .RD_CYC    (RD_CYC),
        .PULSE_CYC (PULSE_CYC),
        .TA_CYC    (TA_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .load      (load),
        .load_val  (load_val),
        .accept    (accept),
        .capture   (capture),
        .ready     (req_ready),
        .done_q    (rsp_valid),
        .strobe_q  (strobe_q)
    );

    asram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_o),
        .rdata_q   (rsp_rdata)
    );

    assign mem_cs_n  = strobe_q.cs_n;
    assign mem_we_n  = strobe_q.we_n;
    assign mem_oe_n  = strobe_q.oe_n;
    assign mem_dq_oe = strobe_q.drive;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R6
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst) (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_o)); // R9
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (!req_ready && req_valid) |=> $stable(mem_addr)); // R2
endmodule

// File: tb/tb_asram_seq.sv
module tb_asram_seq;
    localparam int unsigned AW = 18;
    localparam int unsigned DW = 4;
    localparam int unsigned RD = 3;
    localparam int unsigned WP = 2;
    localparam int unsigned DS = 2;
    localparam int unsigned TA = 1;
    localparam int unsigned PULSE = (WP > DS) ? WP : DS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = '0;

    always #2.5 clk = ~clk;

    asram_seq #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WP_CYC(WP), .DS_CYC(DS), .TA_CYC(TA)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int unsigned tests = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] blank_val(input logic [AW-1:0] a);
        return a[3:0] ^ a[7:4] ^ 4'h5;
    endfunction

    // Memory model and shadow copy
    logic [DW-1:0] model_mem [logic [AW-1:0]];
    logic [DW-1:0] shadow    [logic [AW-1:0]];

    function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
        return model_mem.exists(a) ? model_mem[a] : blank_val(a);
    endfunction
    function automatic logic [DW-1:0] shadow_rd(input logic [AW-1:0] a);
        return shadow.exists(a) ? shadow[a] : blank_val(a);
    endfunction

    typedef struct {
        bit            is_rd;
        logic [DW-1:0] data;
        int unsigned   due;
        string         tag;
    } exp_t;
    exp_t q[$];

    int unsigned   rd_cnt = 0, wl_cnt = 0;
    logic [AW-1:0] wa, prev_addr;
    logic [DW-1:0] wd;
    bit            prev_cs_low = 0;

    always @(negedge clk) begin
        if (!rst) begin
            // read path: true data only once the window is RD cycles old (R3)
            if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
                rd_cnt++;
                mem_dq_i = (rd_cnt >= RD) ? model_rd(mem_addr) : ~model_rd(mem_addr);
            end else begin
                rd_cnt   = 0;
                mem_dq_i = '0;
            end
            // write path
            if (!mem_cs_n && !mem_we_n) begin
                if (wl_cnt != 0) check(mem_dq_o == wd, "R9 data held in pulse", mem_dq_o, wd);
                wl_cnt++;
                wa = mem_addr;
                wd = mem_dq_o;
                check(mem_oe_n == 1'b1, "R4 oe_n high in write", mem_oe_n, 1);
                check(mem_dq_oe == 1'b1, "R5 drive during pulse", mem_dq_oe, 1);
            end else if (wl_cnt != 0) begin
                check(wl_cnt == PULSE, "R9 pulse length", wl_cnt, PULSE);
                check(mem_dq_oe == 1'b1 && !mem_cs_n, "R5 drive one cycle after pulse", mem_dq_oe, 1);
                model_mem[wa] = wd;
                wl_cnt = 0;
            end
            if (!mem_we_n) check(!mem_cs_n, "R4 we inside cs", mem_cs_n, 0);
            if (mem_dq_oe) check(mem_oe_n && !mem_cs_n, "R5 drive only when safe", {mem_oe_n, mem_cs_n}, 2'b10);
            if (!mem_cs_n && prev_cs_low) check(mem_addr == prev_addr, "R6 address stable", mem_addr, prev_addr);
            prev_cs_low = !mem_cs_n;
            prev_addr   = mem_addr;
            // scoreboard monitor
            if (q.size() != 0 && !rsp_valid) check(!req_ready, "R7 ready low while busy", req_ready, 0);
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.due, {e.tag, " response cycle"}, cyc, e.due);
                    if (e.is_rd) check(rsp_rdata == e.data, {e.tag, " read data"}, rsp_rdata, e.data);
                end
            end
        end
    end

    // Driver: pushes the expected response with its due cycle
    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        e.is_rd = !wr;
        e.due   = cyc + (wr ? PULSE + 1 : RD + TA);
        e.data  = wr ? d : shadow_rd(a);
        e.tag   = tag;
        if (wr) shadow[a] = d;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110, "R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110, "R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        check(req_ready && !rsp_valid, "R1 ready idle", {req_ready, rsp_valid}, 2'b10);

        // R8: corners of the address space
        do_op(1'b1, 18'h00000, 4'hA, "R8 wr low");
        do_op(1'b1, 18'h3FFFF, 4'h3, "R8 wr high");
        do_op(1'b1, 18'h15555, 4'hF, "R8 wr mid");
        do_op(1'b0, 18'h00000, 4'h0, "R3 rd low");
        do_op(1'b0, 18'h3FFFF, 4'h0, "R3 rd high");
        do_op(1'b0, 18'h15555, 4'h0, "R3 rd mid");
        do_op(1'b0, 18'h2A0C3, 4'h0, "R3 rd unwritten");
        // overwrite and immediate read-back
        do_op(1'b1, 18'h15555, 4'h0, "R8 overwrite");
        do_op(1'b0, 18'h15555, 4'h0, "R8 read after overwrite");
        // R2: stray request while busy has no effect
        do_op(1'b1, 18'h00100, 4'h6, "R7 wr before stray");
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00200; req_wdata = 4'h9;
        @(negedge clk);
        check(!req_ready, "R2 stray raised while busy", req_ready, 0);
        req_valid = 1'b0;
        do_op(1'b0, 18'h00200, 4'h0, "R2 stray ignored");
        do_op(1'b0, 18'h00100, 4'h0, "R8 rd after stray");
        // walking pattern, alternating write/read
        for (int i = 0; i < 8; i++) begin
            do_op(1'b1, 18'(i * 18'h4321), 4'(i * 3 + 1), "R9 walk wr");
            do_op(1'b0, 18'(i * 18'h4321), 4'h0, "R8 walk rd");
        end
        drain();
        check(req_ready && mem_cs_n && !mem_dq_oe, "R5 bus released at end", {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule